// File: doc/BRIEF.md
# Bit-Swapped ROM Bank Controller

This block sits between an 8-bit CPU with a 16-bit address bus and its program ROM and battery-backed RAM. The CPU loads a bank register with an I/O write to one port. The written byte passes through a fixed swap of adjacent bit pairs before it is stored. The low six bits of the stored value pick one of 64 ROM banks of 8 KB each.

Four adjacent 8 KB windows in CPU space, from 0x6000 to 0xDFFF, all show the same selected bank. The low part of the address space maps straight onto fixed ROM. The top 8 KB selects the non-volatile RAM. A small gap between fixed ROM and the windows selects nothing.

ROM bytes are stored with their bit pairs swapped. The block applies the same pair swap on every ROM read before the byte reaches the CPU.

Top module: `swapbank_ctrl`

## Requirements
- R1: After reset the stored bank value reads 0x00 on `bank_dbg`, so the windows show bank 0 (extended offset 0x10000).
- R2: The bank register loads only on an I/O write (`io_wr` high at a clock edge) whose low address byte is 0x90. The upper address byte is ignored. Writes to any other low byte leave `bank_dbg` unchanged.
- R3: The stored value is the written byte with each adjacent bit pair exchanged. Stored bit 7 is written bit 6, stored bit 6 is written bit 7, and likewise for pairs 5/4, 3/2 and 1/0.
- R4: For CPU addresses 0x6000 to 0xDFFF, `ext_addr` = 0x10000 + B*0x2000 + (address mod 0x2000), where B is the stored bank bits 5:0. All four 8 KB windows give the same result, and `rom_sel` is high.
- R5: Stored bits 7 and 6 are visible on `bank_dbg` but do not change `ext_addr`.
- R6: For CPU addresses 0x0000 to 0x57FF, `rom_sel` is high, `ram_sel` is low and `ext_addr` equals the CPU address.
- R7: For CPU addresses 0xE000 to 0xFFFF, `ram_sel` is high, `rom_sel` is low and `ext_addr` is 0.
- R8: For CPU addresses 0x5800 to 0x5FFF, both selects are low, `ext_addr` is 0 and `rd_data` is 0xFF.
- R9: While `mem_rd` is high and `rom_sel` is high, `rd_data` is `rom_data` with the same pair swap as R3. In every other case `rd_data` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address (memory or I/O) |
| cpu_wdata | input | 8 | CPU write data |
| io_wr | input | 1 | I/O write strobe |
| mem_rd | input | 1 | Memory read strobe |
| rom_data | input | 8 | Raw byte from ROM storage |
| ext_addr | output | 20 | Extended ROM address |
| rom_sel | output | 1 | ROM region select |
| ram_sel | output | 1 | Non-volatile RAM region select |
| rd_data | output | 8 | Descrambled read data to the CPU |
| bank_dbg | output | 8 | Stored bank value, all eight bits |

## Verification
All 256 byte values are written to the bank port, each with a different upper address byte. After each write the stored value and the mapped address are checked in all four windows. This separates a wrong pair swap from a wrong window offset, and shows that bits 7:6 are ignored by the mapping.

The whole address space is then swept in 256-byte steps with the upper bank bits set. This checks each region boundary and confirms that the gap region returns 0xFF. All 256 ROM bytes are read through the descramble path, with the strobe both high and low.

Writes to neighbouring ports such as 0x91 and 0x10 show that only an exact low-byte match loads the register.

// File: rtl/swapbank_ctrl.sv
module swapbank_ctrl #(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter int          BANK_BITS = 6,
  parameter int          PAGE_BITS = 13,
  parameter logic [7:0]  BANK_PORT = 8'h90,
  parameter int          EXT_W     = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              io_wr,
  input  logic              mem_rd,
  input  logic [DATA_W-1:0] rom_data,
  output logic [EXT_W-1:0]  ext_addr,
  output logic              rom_sel,
  output logic              ram_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] bank_dbg
);
  localparam int          IDX_W     = EXT_W - PAGE_BITS;
  localparam logic [IDX_W-1:0] BANK_BASE = IDX_W'(1 << (ADDR_W - PAGE_BITS));
  localparam logic [ADDR_W-1:0] FIX_END = 16'h5800;
  localparam logic [ADDR_W-1:0] WIN_LO  = 16'h6000;
  localparam logic [ADDR_W-1:0] WIN_END = 16'hE000;

  function automatic logic [DATA_W-1:0] pair_swap(input logic [DATA_W-1:0] v);
    for (int i = 0; i < DATA_W; i += 2) begin
      pair_swap[i]   = v[i+1];
      pair_swap[i+1] = v[i];
    end
  endfunction

  logic [DATA_W-1:0] bank_q;
  logic port_hit, in_fix, in_win, in_ram;

  assign port_hit = io_wr && (cpu_addr[7:0] == BANK_PORT);

  always_ff @(posedge clk) begin
    if (!rst_n)        bank_q <= '0;
    else if (port_hit) bank_q <= pair_swap(cpu_wdata);
  end

  assign in_fix = cpu_addr < FIX_END;
  assign in_win = (cpu_addr >= WIN_LO) && (cpu_addr < WIN_END);
  assign in_ram = cpu_addr >= WIN_END;

  assign rom_sel  = in_fix | in_win;
  assign ram_sel  = in_ram;
  assign bank_dbg = bank_q;

  always_comb begin
    ext_addr = '0;
    if (in_fix)
      ext_addr = EXT_W'(cpu_addr);
    else if (in_win)
      ext_addr = {BANK_BASE + IDX_W'(bank_q[BANK_BITS-1:0]), cpu_addr[PAGE_BITS-1:0]};
  end

  assign rd_data = (mem_rd && rom_sel) ? pair_swap(rom_data) : '1;

  // R2
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && cpu_addr[7:0] == BANK_PORT) |=> $stable(bank_dbg));

  // R7
  sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_sel, ram_sel}));

  // R4
  win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr >= WIN_LO && cpu_addr < WIN_END) |-> (ext_addr >= EXT_W'(32'h10000) && rom_sel));

  // R8
  gap_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_sel && !ram_sel) |-> (rd_data == '1 && ext_addr == '0));

  // R9
  idle_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd |-> (rd_data == '1));
endmodule

// File: tb/test_swapbank_ctrl.sv
module test_swapbank_ctrl;
  localparam int CLK_NS = 10;

  logic        clk = 0, rst_n = 0;
  logic [15:0] cpu_addr = 0;
  logic [7:0]  cpu_wdata = 0, rom_data = 0;
  logic        io_wr = 0, mem_rd = 0;
  logic [19:0] ext_addr;
  logic        rom_sel, ram_sel;
  logic [7:0]  rd_data, bank_dbg;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  swapbank_ctrl i_swapbank_ctrl (
    .clk, .rst_n, .cpu_addr, .cpu_wdata, .io_wr, .mem_rd, .rom_data,
    .ext_addr, .rom_sel, .ram_sel, .rd_data, .bank_dbg);

  function automatic logic [7:0] sw(input logic [7:0] d);
    return ((d & 8'h55) << 1) | ((d & 8'hAA) >> 1);
  endfunction

  function automatic logic [19:0] exp_ext(input logic [15:0] a, input logic [7:0] b);
    if (a < 16'h5800) return {4'h0, a};
    if (a >= 16'h6000 && a < 16'hE000)
      return 20'h10000 + 20'(b % 64) * 20'h2000 + 20'(a % 16'h2000);
    return 20'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; io_wr = 1;
    @(negedge clk);
    io_wr = 0;
  endtask

  task automatic look(input logic [15:0] a);
    cpu_addr = a;
    #1;
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] cur;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", bank_dbg, 8'h00);
    look(16'h6000);
    chk("R1", ext_addr, 20'h10000);

    for (int v = 0; v < 256; v++) begin
      io_write({8'(v * 7), 8'h90}, 8'(v));
      cur = sw(8'(v));
      chk("R3", bank_dbg, cur);
      for (int w = 0; w < 4; w++) begin
        logic [15:0] a;
        a = 16'h6000 + 16'(w) * 16'h2000 + 16'((v * 37) % 8192);
        look(a);
        chk("R4", ext_addr, exp_ext(a, cur));
        chk("R5", ext_addr, exp_ext(a, cur & 8'h3F));
      end
    end

    io_write(16'h0090, 8'h2D);
    cur = sw(8'h2D);
    io_write(16'h0091, 8'h00);
    chk("R2", bank_dbg, cur);
    io_write(16'h9010, 8'hFF);
    chk("R2", bank_dbg, cur);
    io_write(16'hFF90, 8'hC1);
    cur = sw(8'hC1);
    chk("R2", bank_dbg, cur);

    mem_rd = 1; rom_data = 8'h5A;
    for (int a = 0; a < 65536; a += 256) begin
      logic [15:0] ad;
      ad = 16'(a) + 16'((a >> 8) & 8'hFF);
      look(ad);
      if (ad < 16'h5800) begin
        chk("R6", {rom_sel, ram_sel}, 2'b10);
        chk("R6", ext_addr, exp_ext(ad, cur));
      end else if (ad < 16'h6000) begin
        chk("R8", {rom_sel, ram_sel}, 2'b00);
        chk("R8", {ext_addr, rd_data}, {20'h0, 8'hFF});
      end else if (ad < 16'hE000) begin
        chk("R4", rom_sel, 1'b1);
        chk("R4", ext_addr, exp_ext(ad, cur));
      end else begin
        chk("R7", {rom_sel, ram_sel}, 2'b01);
        chk("R7", ext_addr, 20'h0);
      end
    end
    look(16'h57FF); chk("R6", rom_sel, 1'b1);
    look(16'h5800); chk("R8", rom_sel, 1'b0);
    look(16'h5FFF); chk("R8", rd_data, 8'hFF);
    look(16'hDFFF); chk("R4", ext_addr, exp_ext(16'hDFFF, cur));
    look(16'hE000); chk("R7", ram_sel, 1'b1);

    for (int d = 0; d < 256; d++) begin
      rom_data = 8'(d);
      mem_rd = 1; look(16'(d * 64));
      chk("R9", rd_data, sw(8'(d)));
      mem_rd = 0; #1;
      chk("R9", rd_data, 8'hFF);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule